// File: doc/BRIEF.md
# Word-Wide Shift Register with GF(2^8) Feedback

This block is the linear part of a word-oriented stream cipher core. It holds sixteen 32-bit stages. On each enabled step the whole register moves one place towards stage 0, and a new word is computed and written into stage 15. That word is formed from whole stages, not single bits. Stage 0 and stage 11 each contribute a byte shift plus a byte-to-word expansion: a multiply by a fixed field element for stage 0, and a divide by that element for stage 11. Stage 2 is XORed in as it stands. The field arithmetic is done inside the block as fixed XOR networks, with no lookup memory.

A controller loads all sixteen stages at once, then runs the register in one of two modes. In initialization mode it injects an external word into every feedback value. In keystream mode it does not. Five stages are brought out for the surrounding nonlinear logic.

Top module: `wlfsr_field`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every stage clears to zero.
- R2: When `load_en` is high, stage k takes `load_data[32k+31:32k]` for k = 0..15. Load wins over `step_en` when both are high.
- R3: When `step_en` is high and `load_en` is low, stage k takes the old stage k+1 for k = 0..14.
- R4: In keystream mode (`init_mode` = 0), stage 15 takes the XOR of five terms, all using old values: (s0 << 8) with the low byte zero, MA(s0[31:24]), s2, (s11 >> 8) with the top byte zero, and DA(s11[7:0]).
- R5: In initialization mode (`init_mode` = 1), `inject_word` is also XORed into the new stage 15. In keystream mode `inject_word` has no effect.
- R6: MA(c) is a 32-bit word. Bits [31:24], [23:16], [15:8] and [7:0] are X^23(c), X^245(c), X^48(c) and X^239(c). X(v) is v shifted left one bit, XORed with 0xA9 when v[7] was 1. X^n applies X n times, and X^0 is the identity.
- R7: DA(c) is built the same way as MA, with powers 16, 39, 6 and 64 for bits [31:24] down to [7:0].
- R8: With `step_en` and `load_en` both low, every stage holds its value.
- R9: `tap_s0`, `tap_s2`, `tap_s5`, `tap_s11` and `tap_s15` show stages 0, 2, 5, 11 and 15 directly from the registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| load_en | input | 1 | Parallel load of all stages |
| load_data | input | 512 | Load image, stage k at bits [32k+31:32k] |
| step_en | input | 1 | Advance the register one step |
| init_mode | input | 1 | 1 = initialization mode, 0 = keystream mode |
| inject_word | input | 32 | Word XORed into feedback in initialization mode |
| tap_s0 | output | 32 | Stage 0 |
| tap_s2 | output | 32 | Stage 2 |
| tap_s5 | output | 32 | Stage 5 |
| tap_s11 | output | 32 | Stage 11 |
| tap_s15 | output | 32 | Stage 15 |

## Verification
Every load, step or reset takes effect at the first rising edge after it is applied. The taps come straight from the stage registers, so each result is visible on the ports one clock after the stimulus, with no further delay. The bench changes inputs on the falling edge and samples the taps on the next falling edge, so each sample falls half a period after the edge that produced it. Its reference model advances exactly once per sampled cycle, and a run of steps walks every stage past the taps.

// File: rtl/wlfsr_pkg.sv
package wlfsr_pkg;

   localparam int unsigned BYTE_W = 8;
   localparam logic [7:0] FIELD_POLY = 8'hA9;

   // byte-lane powers, most significant lane first
   localparam logic [31:0] MUL_POWERS = {8'd23, 8'd245, 8'd48, 8'd239};
   localparam logic [31:0] DIV_POWERS = {8'd16, 8'd39, 8'd6, 8'd64};

   // stage indices that leave the block or feed back
   localparam int unsigned IDX_S0  = 0;
   localparam int unsigned IDX_S2  = 2;
   localparam int unsigned IDX_S5  = 5;
   localparam int unsigned IDX_S11 = 11;
   localparam int unsigned IDX_S15 = 15;

   // repeated multiply-by-x, evaluated only at elaboration time
   function automatic logic [7:0] xtime_pow(input logic [7:0] v,
                                            input int unsigned n,
                                            input logic [7:0] poly);
      logic [7:0] acc;
      acc = v;
      for (int unsigned i = 0; i < n; i++) begin
         acc = acc[7] ? ((acc << 1) ^ poly) : (acc << 1);
      end
      return acc;
   endfunction

endpackage

// File: rtl/wlfsr_alpha_xform.sv
module wlfsr_alpha_xform #(
   parameter int unsigned     LANES    = 4,
   parameter logic [LANES*8-1:0] POW_LIST = wlfsr_pkg::MUL_POWERS,
   parameter logic [7:0]      POLY     = wlfsr_pkg::FIELD_POLY
) (
   input  logic [7:0]         byte_in,
   output logic [LANES*8-1:0] word_out
);
   localparam int unsigned OUT_W = LANES * 8;

   if (LANES == 0) begin : g_bad_lanes
      $error("wlfsr_alpha_xform: LANES must be nonzero");
   end

   // Each lane is linear in byte_in: the sum of the basis images of its set bits.
   for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
      localparam int unsigned LSB = (LANES - 1 - ln) * 8;
      localparam int unsigned POW = int'(POW_LIST[LSB +: 8]);
      logic [7:0][7:0] term;
      logic [7:0]      lane_acc;

      for (genvar b = 0; b < 8; b++) begin : g_bit
         localparam logic [7:0] BASIS =
            wlfsr_pkg::xtime_pow(8'(1 << b), POW, POLY);
         assign term[b] = byte_in[b] ? BASIS : 8'h00;
      end

      always_comb begin
         lane_acc = 8'h00;
         for (int b = 0; b < 8; b++) begin
            lane_acc = lane_acc ^ term[b];
         end
      end

      assign word_out[LSB +: 8] = lane_acc;
   end

   // zero maps to zero for any linear map
   always_comb begin
      if (byte_in == 8'h00) begin
         AST_ZERO_MAP: assert (word_out == '0); // R6
      end
   end

   logic unused_w;
   assign unused_w = ^OUT_W;
endmodule

// File: rtl/wlfsr_feedback.sv
module wlfsr_feedback #(
   parameter int unsigned WORD_W = 32
) (
   input  logic [WORD_W-1:0] s0_w,
   input  logic [WORD_W-1:0] s2_w,
   input  logic [WORD_W-1:0] s11_w,
   input  logic              init_mode,
   input  logic [WORD_W-1:0] inject_word,
   output logic [WORD_W-1:0] fb_word
);
   localparam int unsigned LANES = WORD_W / wlfsr_pkg::BYTE_W;

   if (WORD_W != 32) begin : g_bad_width
      $error("wlfsr_feedback: the field powers are defined for 32-bit words");
   end

   logic [WORD_W-1:0] mul_term;
   logic [WORD_W-1:0] div_term;
   logic [WORD_W-1:0] lin_part;

   wlfsr_alpha_xform #(
      .LANES   (LANES),
      .POW_LIST(wlfsr_pkg::MUL_POWERS),
      .POLY    (wlfsr_pkg::FIELD_POLY)
   ) u_mul (
      .byte_in (s0_w[WORD_W-1 -: 8]),
      .word_out(mul_term)
   );

   wlfsr_alpha_xform #(
      .LANES   (LANES),
      .POW_LIST(wlfsr_pkg::DIV_POWERS),
      .POLY    (wlfsr_pkg::FIELD_POLY)
   ) u_div (
      .byte_in (s11_w[7:0]),
      .word_out(div_term)
   );

   always_comb begin
      lin_part = {s0_w[WORD_W-9:0], 8'h00}
               ^ mul_term
               ^ s2_w
               ^ {8'h00, s11_w[WORD_W-1:8]}
               ^ div_term;
      fb_word  = init_mode ? (lin_part ^ inject_word) : lin_part;
   end

   always_comb begin
      if (init_mode == 1'b0) begin
         AST_KS_NO_INJECT: assert (fb_word == lin_part); // R5
      end
   end
endmodule

// File: rtl/wlfsr_stages.sv
module wlfsr_stages #(
   parameter int unsigned WORD_W     = 32,
   parameter int unsigned NUM_STAGES = 16
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         load_en,
   input  logic [NUM_STAGES*WORD_W-1:0] load_data,
   input  logic                         step_en,
   input  logic [WORD_W-1:0]            fb_word,
   output logic [NUM_STAGES*WORD_W-1:0] state_flat
);
   localparam int unsigned LAST = NUM_STAGES - 1;

   if (NUM_STAGES < 2) begin : g_bad_depth
      $error("wlfsr_stages: at least two stages are needed");
   end

   logic [WORD_W-1:0] st [NUM_STAGES];

   for (genvar k = 0; k < NUM_STAGES; k++) begin : g_stage
      logic [WORD_W-1:0] shift_in;
      if (k == LAST) begin : g_top
         assign shift_in = fb_word;
      end else begin : g_mid
         assign shift_in = st[k+1];
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            st[k] <= '0;
         end else if (load_en) begin
            st[k] <= load_data[k*WORD_W +: WORD_W];
         end else if (step_en) begin
            st[k] <= shift_in;
         end
      end

      assign state_flat[k*WORD_W +: WORD_W] = st[k];
   end

   AST_RESET_CLEAR: assert property (@(posedge clk)
      !rst_n |=> (st[0] == '0 && st[LAST] == '0)); // R1

   AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      load_en |=> (st[0] == $past(load_data[WORD_W-1:0])
                   && st[LAST] == $past(load_data[LAST*WORD_W +: WORD_W]))); // R2

   AST_SHIFT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && !load_en) |=> (st[0] == $past(st[1])
                                 && st[LAST-1] == $past(st[LAST]))); // R3

   AST_FB_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && !load_en) |=> (st[LAST] == $past(fb_word))); // R4

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!step_en && !load_en) |=> ($stable(st[0]) && $stable(st[LAST]))); // R8
endmodule

// File: rtl/wlfsr_field.sv
module wlfsr_field #(
   parameter int unsigned WORD_W     = 32,
   parameter int unsigned NUM_STAGES = 16
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         load_en,
   input  logic [NUM_STAGES*WORD_W-1:0] load_data,
   input  logic                         step_en,
   input  logic                         init_mode,
   input  logic [WORD_W-1:0]            inject_word,
   output logic [WORD_W-1:0]            tap_s0,
   output logic [WORD_W-1:0]            tap_s2,
   output logic [WORD_W-1:0]            tap_s5,
   output logic [WORD_W-1:0]            tap_s11,
   output logic [WORD_W-1:0]            tap_s15
);
   import wlfsr_pkg::*;

   if (NUM_STAGES != 16) begin : g_bad_stages
      $error("wlfsr_field: the tap positions require 16 stages");
   end

   logic [NUM_STAGES*WORD_W-1:0] state_flat;
   logic [WORD_W-1:0]            fb_word;

   assign tap_s0  = state_flat[IDX_S0  * WORD_W +: WORD_W];
   assign tap_s2  = state_flat[IDX_S2  * WORD_W +: WORD_W];
   assign tap_s5  = state_flat[IDX_S5  * WORD_W +: WORD_W];
   assign tap_s11 = state_flat[IDX_S11 * WORD_W +: WORD_W];
   assign tap_s15 = state_flat[IDX_S15 * WORD_W +: WORD_W];

   wlfsr_feedback #(.WORD_W(WORD_W)) u_fb (
      .s0_w       (tap_s0),
      .s2_w       (tap_s2),
      .s11_w      (tap_s11),
      .init_mode  (init_mode),
      .inject_word(inject_word),
      .fb_word    (fb_word)
   );

   wlfsr_stages #(.WORD_W(WORD_W), .NUM_STAGES(NUM_STAGES)) u_stages (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_en   (load_en),
      .load_data (load_data),
      .step_en   (step_en),
      .fb_word   (fb_word),
      .state_flat(state_flat)
   );
endmodule

// File: tb/wlfsr_field_tb_top.sv
module wlfsr_field_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int W = 32;
   localparam int N = 16;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           load_en = 1'b0;
   logic [N*W-1:0] load_data = '0;
   logic           step_en = 1'b0;
   logic           init_mode = 1'b0;
   logic [W-1:0]   inject_word = '0;
   logic [W-1:0]   tap_s0, tap_s2, tap_s5, tap_s11, tap_s15;

   int n_vec = 0;
   int n_bad = 0;
   bit done  = 0;
   logic [W-1:0] mdl [N];

   always #(CLK_PERIOD/2) clk = ~clk;

   wlfsr_field dut_i (
      .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_data(load_data),
      .step_en(step_en), .init_mode(init_mode), .inject_word(inject_word),
      .tap_s0(tap_s0), .tap_s2(tap_s2), .tap_s5(tap_s5),
      .tap_s11(tap_s11), .tap_s15(tap_s15)
   );

   // ---------------- reference arithmetic ----------------
   function automatic logic [7:0] m_pow(input logic [7:0] v, input int n);
      logic [7:0] a = v;
      for (int i = 0; i < n; i++) a = a[7] ? ((a << 1) ^ 8'hA9) : (a << 1);
      return a;
   endfunction

   function automatic logic [31:0] m_ma(input logic [7:0] c);
      return {m_pow(c, 23), m_pow(c, 245), m_pow(c, 48), m_pow(c, 239)};
   endfunction

   function automatic logic [31:0] m_da(input logic [7:0] c);
      return {m_pow(c, 16), m_pow(c, 39), m_pow(c, 6), m_pow(c, 64)};
   endfunction

   function automatic logic [31:0] m_fb(input logic im, input logic [31:0] inj);
      logic [31:0] f;
      f = {mdl[0][23:0], 8'h00} ^ m_ma(mdl[0][31:24]) ^ mdl[2]
        ^ {8'h00, mdl[11][31:8]} ^ m_da(mdl[11][7:0]);
      if (im) f = f ^ inj;
      return f;
   endfunction

   task automatic mdl_step(input logic im, input logic [31:0] inj);
      logic [31:0] f = m_fb(im, inj);
      for (int k = 0; k < N - 1; k++) mdl[k] = mdl[k+1];
      mdl[N-1] = f;
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
      end
   endtask

   task automatic chk_taps(input string tag);
      chk({tag, " s0"},  tap_s0,  mdl[0]);
      chk({tag, " s2"},  tap_s2,  mdl[2]);
      chk({tag, " s5"},  tap_s5,  mdl[5]);
      chk({tag, " s11"}, tap_s11, mdl[11]);
      chk({tag, " s15"}, tap_s15, mdl[15]);
   endtask

   // All tasks start and end on a falling edge.
   task automatic do_load(input logic [N*W-1:0] img, input logic also_step);
      load_en = 1'b1; load_data = img; step_en = also_step;
      inject_word = 32'hFFFF_FFFF; init_mode = 1'b1;
      @(negedge clk);
      load_en = 1'b0; step_en = 1'b0;
      for (int k = 0; k < N; k++) mdl[k] = img[k*W +: W];
   endtask

   task automatic do_step(input logic im, input logic [31:0] inj);
      step_en = 1'b1; init_mode = im; inject_word = inj;
      @(negedge clk);
      step_en = 1'b0;
      mdl_step(im, inj);
   endtask

   function automatic logic [N*W-1:0] rand_img();
      logic [N*W-1:0] r;
      for (int k = 0; k < N; k++) r[k*W +: W] = $urandom;
      return r;
   endfunction

   // ---------------- scenarios ----------------
   task automatic t_reset();
      do_load(rand_img(), 1'b0);
      rst_n = 1'b0;
      @(negedge clk);
      for (int k = 0; k < N; k++) mdl[k] = '0;
      chk_taps("R1 reset");
      rst_n = 1'b1;
   endtask

   task automatic t_load_walk();
      logic [N*W-1:0] img;
      for (int k = 0; k < N; k++) img[k*W +: W] = 32'h1111_0000 + 32'(k);
      do_load(img, 1'b0);
      chk_taps("R2 R9 load");
      // walk all stages through s0 and s15 in keystream mode
      for (int i = 0; i < N; i++) begin
         do_step(1'b0, 32'h0);
         chk_taps("R3 R4 walk");
      end
   endtask

   task automatic t_mul_alpha();
      logic [N*W-1:0] img = '0;
      img[31:0] = 32'h0100_0000;
      do_load(img, 1'b0);
      do_step(1'b0, 32'h0);
      chk("R6 MA(01)", tap_s15, m_ma(8'h01));
      img[31:0] = 32'h80_000000;
      do_load(img, 1'b0);
      do_step(1'b0, 32'h0);
      chk("R6 MA(80)", tap_s15, m_ma(8'h80));
   endtask

   task automatic t_div_alpha();
      logic [N*W-1:0] img = '0;
      img[11*W +: W] = 32'h0000_0001;
      do_load(img, 1'b0);
      do_step(1'b0, 32'h0);
      chk("R7 DA(01)", tap_s15, m_da(8'h01));
      img[11*W +: W] = 32'h0000_00FF;
      do_load(img, 1'b0);
      do_step(1'b0, 32'h0);
      chk("R7 DA(ff)", tap_s15, m_da(8'hFF));
   endtask

   task automatic t_shift_terms();
      logic [N*W-1:0] img = '0;
      img[31:0]       = 32'h00AB_CDEF;
      img[2*W +: W]   = 32'h1234_5678;
      img[11*W +: W]  = 32'hFEDC_BA00;
      do_load(img, 1'b0);
      do_step(1'b0, 32'h0);
      chk("R4 byte shifts", tap_s15, 32'hABCD_EF00 ^ 32'h1234_5678 ^ 32'h00FE_DCBA);
   endtask

   task automatic t_init_mode();
      do_load(rand_img(), 1'b0);
      for (int i = 0; i < 20; i++) begin
         do_step(1'b1, $urandom);
         chk_taps("R5 init inject");
      end
      // inject ignored in keystream mode
      for (int i = 0; i < 20; i++) begin
         do_step(1'b0, $urandom | 32'h1);
         chk_taps("R5 keystream ignores inject");
      end
   endtask

   task automatic t_priority();
      logic [N*W-1:0] img = rand_img();
      do_step(1'b0, 32'h0);
      do_load(img, 1'b1);
      chk_taps("R2 load over step");
   endtask

   task automatic t_hold();
      do_load(rand_img(), 1'b0);
      for (int i = 0; i < 4; i++) begin
         init_mode = i[0]; inject_word = $urandom;
         @(negedge clk);
         chk_taps("R8 idle hold");
      end
   endtask

   task automatic t_mixed();
      for (int r = 0; r < 8; r++) begin
         do_load(rand_img(), 1'b0);
         for (int i = 0; i < 48; i++) begin
            if ($urandom_range(3) == 0) begin
               @(negedge clk);
            end else begin
               do_step(1'($urandom_range(1)), $urandom);
            end
            chk_taps("R3 R4 R5 mixed");
         end
      end
   endtask

   initial begin
      for (int k = 0; k < N; k++) mdl[k] = '0;
      repeat (3) @(negedge clk);
      chk_taps("R1 power-up reset");
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_load_walk();
      t_mul_alpha();
      t_div_alpha();
      t_shift_terms();
      t_init_mode();
      t_priority();
      t_hold();
      t_mixed();
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule